// File: doc/BRIEF.md
# Unit Clause Implication Checker

This block looks at one clause at a time and decides, in a single cycle of combinational logic, whether the clause forces a value on one of its variables. A clause arrives as a packed vector of 2-bit status fields, one per literal. The block reports one of five outcomes: an implication at a given literal position, a satisfied clause, a conflicting clause (every literal false), an illegal encoding, or none of these (the clause is still open).

A host or clause-fetch engine drives clause records into a valid/ready input and collects one result record per clause from a valid/ready output. A single register stage holds the result. The input is ready whenever that stage is empty or is being drained in the same cycle. If the consumer holds `out_ready` low, the result stays frozen and `in_ready` drops, so back-pressure passes straight upstream. Nothing is lost and nothing is duplicated. The clause identifier travels with the result, so the consumer knows which clause an implication belongs to.

Top module: `unit_clause_checker`

## Requirements
- R1: Literal i occupies bits [2i+1:2i] of `in_stat`. The codes are 00 = false, 01 = true, 10 = unassigned and 11 = illegal.
- R2: When field i is 10 and every other field is 00, the result has `out_imply`=1 and `out_pos`=i in binary. All other flags are 0.
- R3: When no field is 01 or 11 and two or more fields are 10, all four flags are 0.
- R4: When no field is 11 and at least one field is 01, `out_sat`=1 and `out_imply`=`out_conflict`=0.
- R5: When every field is 00, `out_conflict`=1 and the other flags are 0.
- R6: When any field is 11, `out_error`=1 and the other flags are 0. At most one flag is ever high.
- R7: `out_pos` is 0 whenever `out_imply` is 0. `out_cid` equals the `in_cid` of the accepted clause.
- R8: A clause is accepted on a rising edge with `in_valid` and `in_ready` both high. Its result is on the outputs with `out_valid`=1 right after that edge. When `out_valid` and `out_ready` are both high and no new clause is accepted, `out_valid` falls after the edge.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and every output holds its value.
- R10: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Clause record offered |
| in_ready | output | 1 | Block can take a clause this cycle |
| in_cid | input | CID_W | Clause identifier |
| in_stat | input | 2*NLIT | Packed literal status fields |
| out_valid | output | 1 | Result record present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_cid | output | CID_W | Identifier of the evaluated clause |
| out_imply | output | 1 | Clause is unit and forces a literal |
| out_pos | output | POS_W | Binary position of the forced literal |
| out_sat | output | 1 | Some literal is true |
| out_conflict | output | 1 | Every literal is false |
| out_error | output | 1 | An illegal status code was seen |

## Verification
Every result is due exactly one rising edge after its clause is accepted. The bench drives inputs on the falling edge and compares the outputs on the next falling edge, which is half a period after the accepting edge. During the stall test the bench holds `out_ready` low for several cycles and checks on each falling edge that the result and `in_ready` stay put. It then releases `out_ready` and checks that the queued clause appears one edge later.

// File: rtl/ucc_pkg.sv
package ucc_pkg;
  typedef enum logic [1:0] {
    LIT_FALSE = 2'b00,
    LIT_TRUE  = 2'b01,
    LIT_UNAS  = 2'b10,
    LIT_BAD   = 2'b11
  } lit_stat_e;
endpackage

// File: rtl/ucc_field_decode.sv
module ucc_field_decode #(
  parameter int NLIT = 4
) (
  input  logic [2*NLIT-1:0] stat,
  output logic [NLIT-1:0]   f_false,
  output logic [NLIT-1:0]   f_true,
  output logic [NLIT-1:0]   f_unas,
  output logic [NLIT-1:0]   f_bad
);
  import ucc_pkg::*;

  for (genvar i = 0; i < NLIT; i++) begin : g_fld
    lit_stat_e code;
    assign code       = lit_stat_e'(stat[2*i +: 2]);
    assign f_false[i] = (code == LIT_FALSE);
    assign f_true[i]  = (code == LIT_TRUE);
    assign f_unas[i]  = (code == LIT_UNAS);
    assign f_bad[i]   = (code == LIT_BAD);
  end
endmodule

// File: rtl/ucc_unit_detect.sv
module ucc_unit_detect #(
  parameter int NLIT  = 4,
  parameter int POS_W = 2
) (
  input  logic [NLIT-1:0]  f_false,
  input  logic [NLIT-1:0]  f_unas,
  output logic             hit_any,
  output logic [POS_W-1:0] hit_pos
);
  logic [NLIT-1:0] hit;

  // position i is forced when it is open and all others are false
  for (genvar i = 0; i < NLIT; i++) begin : g_pos
    localparam logic [NLIT-1:0] SELF = NLIT'(1) << i;
    assign hit[i] = f_unas[i] && ((f_false | SELF) == {NLIT{1'b1}});
  end

  // hit is one-hot or zero, so an OR of indices is the binary code
  always_comb begin
    hit_pos = '0;
    for (int i = 0; i < NLIT; i++) begin
      if (hit[i]) hit_pos = hit_pos | POS_W'(i);
    end
  end

  assign hit_any = |hit;
endmodule

// File: rtl/ucc_out_stage.sv
module ucc_out_stage #(
  parameter int CID_W = 16,
  parameter int POS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CID_W-1:0] nxt_cid,
  input  logic             nxt_imply,
  input  logic [POS_W-1:0] nxt_pos,
  input  logic             nxt_sat,
  input  logic             nxt_conflict,
  input  logic             nxt_error,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CID_W-1:0] out_cid,
  output logic             out_imply,
  output logic [POS_W-1:0] out_pos,
  output logic             out_sat,
  output logic             out_conflict,
  output logic             out_error
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_cid      <= '0;
      out_imply    <= 1'b0;
      out_pos      <= '0;
      out_sat      <= 1'b0;
      out_conflict <= 1'b0;
      out_error    <= 1'b0;
    end else if (load) begin
      out_valid    <= 1'b1;
      out_cid      <= nxt_cid;
      out_imply    <= nxt_imply;
      out_pos      <= nxt_pos;
      out_sat      <= nxt_sat;
      out_conflict <= nxt_conflict;
      out_error    <= nxt_error;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/unit_clause_checker.sv
module unit_clause_checker #(
  parameter int NLIT  = 4,
  parameter int CID_W = 16,
  localparam int POS_W = (NLIT > 1) ? $clog2(NLIT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CID_W-1:0]  in_cid,
  input  logic [2*NLIT-1:0] in_stat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CID_W-1:0]  out_cid,
  output logic              out_imply,
  output logic [POS_W-1:0]  out_pos,
  output logic              out_sat,
  output logic              out_conflict,
  output logic              out_error
);
  logic [NLIT-1:0]  f_false, f_true, f_unas, f_bad;
  logic             unit_hit;
  logic [POS_W-1:0] unit_pos;
  logic             c_err, c_sat, c_conf, c_imp;
  logic [POS_W-1:0] c_pos;

  ucc_field_decode #(.NLIT(NLIT)) u_dec (
    .stat    (in_stat),
    .f_false (f_false),
    .f_true  (f_true),
    .f_unas  (f_unas),
    .f_bad   (f_bad)
  );

  ucc_unit_detect #(.NLIT(NLIT), .POS_W(POS_W)) u_det (
    .f_false (f_false),
    .f_unas  (f_unas),
    .hit_any (unit_hit),
    .hit_pos (unit_pos)
  );

  // illegal code outranks every other verdict
  assign c_err  = |f_bad;
  assign c_sat  = !c_err && (|f_true);
  assign c_conf = !c_err && (&f_false);
  assign c_imp  = !c_err && unit_hit;
  assign c_pos  = c_imp ? unit_pos : '0;

  ucc_out_stage #(.CID_W(CID_W), .POS_W(POS_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .nxt_cid      (in_cid),
    .nxt_imply    (c_imp),
    .nxt_pos      (c_pos),
    .nxt_sat      (c_sat),
    .nxt_conflict (c_conf),
    .nxt_error    (c_err),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_cid      (out_cid),
    .out_imply    (out_imply),
    .out_pos      (out_pos),
    .out_sat      (out_sat),
    .out_conflict (out_conflict),
    .out_error    (out_error)
  );
endmodule

// File: rtl/ucc_checker.sv
module ucc_checker #(
  parameter int CID_W = 16,
  parameter int POS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CID_W-1:0] out_cid,
  input logic             out_imply,
  input logic [POS_W-1:0] out_pos,
  input logic             out_sat,
  input logic             out_conflict,
  input logic             out_error
);
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_imply, out_sat, out_conflict, out_error}));

  assert_pos_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_imply) |-> (out_pos == '0));

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_stall_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cid) && $stable(out_pos)
      && $stable({out_imply, out_sat, out_conflict, out_error})));
endmodule

bind unit_clause_checker ucc_checker #(.CID_W(CID_W), .POS_W(POS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_cid      (out_cid),
  .out_imply    (out_imply),
  .out_pos      (out_pos),
  .out_sat      (out_sat),
  .out_conflict (out_conflict),
  .out_error    (out_error)
);

// File: tb/sim_unit_clause_checker.sv
module sim_unit_clause_checker;
  localparam int NLIT  = 4;
  localparam int CID_W = 16;
  localparam int POS_W = 2;
  localparam int NVEC  = 12;

  // entry: {stat[7:0], imply, sat, conflict, error, pos[1:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {8'b00_00_00_10, 4'b1000, 2'd0},
    {8'b00_00_10_00, 4'b1000, 2'd1},
    {8'b00_10_00_00, 4'b1000, 2'd2},
    {8'b10_00_00_00, 4'b1000, 2'd3},
    {8'b00_00_00_00, 4'b0010, 2'd0},
    {8'b00_01_00_00, 4'b0100, 2'd0},
    {8'b01_10_10_10, 4'b0100, 2'd0},
    {8'b00_00_00_01, 4'b0100, 2'd0},
    {8'b10_00_10_00, 4'b0000, 2'd0},
    {8'b10_10_10_10, 4'b0000, 2'd0},
    {8'b11_00_00_10, 4'b0001, 2'd0},
    {8'b01_00_11_00, 4'b0001, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CID_W-1:0] in_cid = '0;
  logic [2*NLIT-1:0] in_stat = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [CID_W-1:0] out_cid;
  logic out_imply, out_sat, out_conflict, out_error;
  logic [POS_W-1:0] out_pos;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  unit_clause_checker #(.NLIT(NLIT), .CID_W(CID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_cid(in_cid), .in_stat(in_stat), .out_valid(out_valid),
    .out_ready(out_ready), .out_cid(out_cid), .out_imply(out_imply),
    .out_pos(out_pos), .out_sat(out_sat), .out_conflict(out_conflict),
    .out_error(out_error)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string flag_tag(input logic [3:0] f);
    case (f)
      4'b1000: return "R2";
      4'b0100: return "R4";
      4'b0010: return "R5";
      4'b0001: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out_valid idle", int'(out_valid), 0);

    // table walk, one clause per cycle, consumer always ready
    for (int k = 0; k < NVEC; k++) begin
      in_valid = 1'b1;
      in_cid   = CID_W'(16'h100 + k);
      in_stat  = VEC[k][13:6];
      @(negedge clk);
      chk($sformatf("R8 out_valid vec %0d", k), int'(out_valid), 1);
      chk($sformatf("%s flags vec %0d", flag_tag(VEC[k][5:2]), k),
          int'({out_imply, out_sat, out_conflict, out_error}), int'(VEC[k][5:2]));
      chk($sformatf("R1/R2/R7 pos vec %0d", k), int'(out_pos), int'(VEC[k][1:0]));
      chk($sformatf("R7 cid vec %0d", k), int'(out_cid), 16'h100 + k);
    end

    // drain: no new clause, result consumed
    in_valid = 1'b0;
    @(negedge clk);
    chk("R8 out_valid falls after drain", int'(out_valid), 0);

    // back-pressure
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_cid    = CID_W'(16'h0A5);
    in_stat   = 8'b00_10_00_00;
    @(negedge clk);
    in_cid  = CID_W'(16'h05A);
    in_stat = 8'b00_00_00_00;
    for (int s = 0; s < 3; s++) begin
      chk("R9 in_ready low in stall", int'(in_ready), 0);
      chk("R9 held cid", int'(out_cid), 16'h0A5);
      chk("R9 held imply", int'(out_imply), 1);
      chk("R9 held pos", int'(out_pos), 2);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 queued cid after release", int'(out_cid), 16'h05A);
    chk("R5 queued conflict", int'(out_conflict), 1);
    chk("R7 queued pos zero", int'(out_pos), 0);

    // reset drops a pending result
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule